// File: doc/BRIEF.md
# ADC Burst Oversampling and Averaging Filter

This block sits behind an ADC and post-processes its stream of 12-bit conversion results, each tagged with a 4-bit channel number. One channel is chosen in a control word. Samples from that channel are summed over a burst of fixed length, and the sum is turned into one filtered output word. The block has two modes.

Oversampling mode trades sample count for resolution. Power-of-four bursts give wider integer results. Power-of-two bursts give results that carry one fractional bit.

Averaging mode divides the sum exactly by the burst length. It returns the average left-aligned in a 16-bit word, with up to four fractional bits below the 12 integer bits.

The control word is written through a simple write strobe. While the converter's global enable input is high, the configuration is frozen: a write is dropped and flags an error.

Top module: `adc_burst_filter`

## Requirements
- R1: After synchronous reset the control word is all zero, which means filtering is off and oversampling mode is selected. `res_valid`, `res_data` and `wr_err` are all 0.
- R2: A write with `glb_en` low loads `wr_data` into the control word at that clock edge. Field positions are: bit 0 filter on, bit 1 mode (0 oversampling, 1 averaging), bit 2 16-bit enable, bits 5:3 ratio code, bits 9:6 channel. The write raises no error.
- R3: A write with `glb_en` high leaves the control word unchanged. It makes `wr_err` high for exactly the one cycle after the write edge.
- R4: A sample is counted only when `smp_valid` is high, the filter-on bit is 1, and `smp_chan` equals the channel field. All other samples have no effect on the burst.
- R5: In oversampling mode, ratio codes 0, 1, 2 and 3 sum 4, 16, 64 and 256 samples. The sum is shifted right by 1, 2, 3 and 4 bits respectively, giving 13- to 16-bit integer results that are zero-extended to 16 bits.
- R6: In oversampling mode, ratio codes 4, 5, 6 and 7 sum 2, 8, 32 and 128 samples. The sum is shifted right by 0, 1, 2 and 3 bits respectively, giving results with one fractional bit in the LSB.
- R7: In averaging mode, ratio codes 0 through 7 sum 2, 4, 8, 16, 32, 64, 128 and 256 samples. The result is floor(sum*16/count), so the 12-bit average sits in bits 15:4.
- R8: In averaging mode, bits 3:0 of the result are kept only when both `frac_sel` and the 16-bit enable are 1. In every other case they are forced to zero.
- R9: `res_valid` is high for exactly one cycle, in the cycle after the edge that takes the final sample of a burst. `res_data` holds its value until the next result. The next burst starts from an empty sum.
- R10: Clearing the filter-on bit, or any accepted control write, discards the partial sum and sample count. The next result uses only samples taken after that point.
- R11: A 256-sample burst of full-scale samples (4095) does not overflow. It yields 65520 both in oversampling code 3 and in averaging code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Converter global enable; locks the control word while high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 10 | Control word write data |
| frac_sel | input | 1 | Fractional output selected for the filtered channel |
| smp_valid | input | 1 | Conversion result strobe |
| smp_data | input | 12 | Conversion result |
| smp_chan | input | 4 | Channel that produced the result |
| res_valid | output | 1 | One-cycle strobe marking a new filtered result |
| res_data | output | 16 | Filtered result word |
| wr_err | output | 1 | One-cycle error pulse for a rejected write |

## Verification
Every ratio code is exercised in both modes with ramp data, so each sample count and shift is checked. A wrong burst length would either report a result too early or produce a wrong value. A wrong shift would scale the result by a power of two.

Samples from other channels, and samples arriving while the filter is off, are interleaved with valid ones. A design that ignored the channel match or the filter-on bit would end bursts early and produce a wrong sum.

A write made while the block is locked must leave the previous setup in force and must raise the error pulse. A leaky lock shows up as the next result being computed with the wrong setup.

A burst is abandoned part-way, and then full-scale 256-sample bursts are run. These catch partial sums that survive the abandon, and accumulators too narrow to hold the largest sum.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int SMP_W   = 12;
  localparam int CHAN_W  = 4;
  localparam int RATIO_W = 3;
  localparam int OUT_W   = 16;
  localparam int LOG_W   = 4;

  typedef struct packed {
    logic [CHAN_W-1:0]  chan;
    logic [RATIO_W-1:0] ratio;
    logic               wide16;
    logic               avg_mode;
    logic               filt_on;
  } adcf_cfg_t;

  localparam int CFG_W = $bits(adcf_cfg_t);

  // log2 of the burst length selected by mode and ratio code
  function automatic logic [LOG_W-1:0] burst_log2(input adcf_cfg_t c);
    logic [LOG_W-1:0] pair;
    pair = {1'b0, c.ratio[1:0], 1'b0};
    if (c.avg_mode)
      burst_log2 = LOG_W'(c.ratio) + LOG_W'(1);
    else if (c.ratio[2])
      burst_log2 = pair + LOG_W'(1);
    else
      burst_log2 = pair + LOG_W'(2);
  endfunction

  // right shift applied to the sum in oversampling mode
  function automatic logic [LOG_W-1:0] os_shift(input adcf_cfg_t c);
    if (c.ratio[2])
      os_shift = LOG_W'(c.ratio[1:0]);
    else
      os_shift = LOG_W'(c.ratio[1:0]) + LOG_W'(1);
  endfunction
endpackage

// File: rtl/adcf_cfg_reg.sv
module adcf_cfg_reg
  import adcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output adcf_cfg_t        cfg,
  output logic             wr_take,
  output logic             wr_err
);
  adcf_cfg_t cfg_q;

  assign wr_take = wr_en && !glb_en;
  assign cfg     = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= wr_en && glb_en;
      if (wr_take)
        cfg_q <= adcf_cfg_t'(wr_data);
    end
  end

  AST_ERR_NEEDS_LOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> ($past(wr_en) && $past(glb_en))); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && (!$past(wr_en) || $past(glb_en))) |-> $stable(cfg_q)); // R3

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wr_err && !(wr_en && glb_en)) |=> !wr_err); // R3
endmodule

// File: rtl/adcf_accum.sv
module adcf_accum
  import adcf_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  adcf_cfg_t         cfg,
  input  logic              restart,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [CHAN_W-1:0] smp_chan,
  output logic              last_hit,
  output logic [ACC_W-1:0]  total
);
  localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'((1 << SMP_W) - 1);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_lim;
  logic             take;

  assign cnt_lim  = (CNT_W'(1) << burst_log2(cfg)) - CNT_W'(1);
  assign take     = smp_valid && cfg.filt_on && !restart && (smp_chan == cfg.chan);
  assign total    = acc_q + ACC_W'(smp_data);
  assign last_hit = take && (cnt_q == cnt_lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !cfg.filt_on) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (last_hit) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= total;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cnt_lim); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    acc_q <= ACC_W'(cnt_q) * FULL_SCALE); // R11

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!cfg.filt_on || restart) |=> (cnt_q == '0 && acc_q == '0)); // R10
endmodule

// File: rtl/adcf_format.sv
module adcf_format
  import adcf_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  adcf_cfg_t        cfg,
  input  logic             frac_sel,
  input  logic             last_hit,
  input  logic [ACC_W-1:0] total,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data
);
  localparam int FRAC_W = OUT_W - SMP_W;
  localparam int WIDE_W = ACC_W + FRAC_W;

  logic [ACC_W-1:0]  os_sum;
  logic [WIDE_W-1:0] avg_sum;
  logic [OUT_W-1:0]  word;

  always_comb begin
    os_sum  = total >> os_shift(cfg);
    avg_sum = {total, {FRAC_W{1'b0}}} >> burst_log2(cfg);
    if (cfg.avg_mode) begin
      word = avg_sum[OUT_W-1:0];
      if (!(frac_sel && cfg.wide16))
        word[FRAC_W-1:0] = '0;
    end else begin
      word = os_sum[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= last_hit;
      if (last_hit)
        res_data <= word;
    end
  end

  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R9

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_data)); // R9
endmodule

// File: rtl/adc_burst_filter.sv
module adc_burst_filter
  import adcf_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              frac_sel,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [CHAN_W-1:0] smp_chan,
  output logic              res_valid,
  output logic [OUT_W-1:0]  res_data,
  output logic              wr_err
);
  adcf_cfg_t        cfg;
  logic             wr_take;
  logic             last_hit;
  logic [ACC_W-1:0] total;

  adcf_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .glb_en  (glb_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .wr_take (wr_take),
    .wr_err  (wr_err)
  );

  adcf_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .restart   (wr_take),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_chan  (smp_chan),
    .last_hit  (last_hit),
    .total     (total)
  );

  adcf_format #(.ACC_W(ACC_W)) u_fmt (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .frac_sel  (frac_sel),
    .last_hit  (last_hit),
    .total     (total),
    .res_valid (res_valid),
    .res_data  (res_data)
  );
endmodule

// File: tb/sim_adc_burst_filter.sv
module sim_adc_burst_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glb_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_data = '0;
  logic        frac_sel = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [3:0]  smp_chan = '0;
  logic        res_valid;
  logic [15:0] res_data;
  logic        wr_err;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  adc_burst_filter u0 (
    .clk(clk), .rst(rst), .glb_en(glb_en), .wr_en(wr_en), .wr_data(wr_data),
    .frac_sel(frac_sel), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .res_valid(res_valid), .res_data(res_data), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2 layout: [0] on, [1] mode, [2] wide16, [5:3] ratio, [9:6] channel
  function automatic logic [9:0] cw(bit on, bit avg, bit wide, int code, int ch);
    return {4'(ch), 3'(code), wide, avg, on};
  endfunction

  function automatic int burst_len(bit avg, int code);
    if (avg) return 2 << code;
    case (code)
      0: return 4;   1: return 16;  2: return 64;  3: return 256;
      4: return 2;   5: return 8;   6: return 32;  default: return 128;
    endcase
  endfunction

  function automatic int expect_word(bit avg, int code, bit frac, bit wide, int sum);
    int v;
    if (!avg) begin
      case (code)
        0: v = sum >> 1; 1: v = sum >> 2; 2: v = sum >> 3; 3: v = sum >> 4;
        4: v = sum;      5: v = sum >> 1; 6: v = sum >> 2; default: v = sum >> 3;
      endcase
    end else begin
      v = (sum * 16) / burst_len(1'b1, code);
      if (!(frac && wide)) v = v & 32'hFFF0;
    end
    return v;
  endfunction

  task automatic wr(input logic [9:0] d, input bit locked, input string tag);
    glb_en = locked; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(wr_err == locked, {tag, " wr_err after write"}, wr_err, locked);
    @(negedge clk);
    glb_en = 1'b0;
    chk(wr_err == 1'b0, {tag, " wr_err one cycle"}, wr_err, 0);
  endtask

  task automatic put(input int d, input int ch);
    smp_valid = 1'b1; smp_data = 12'(d); smp_chan = 4'(ch);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic burst_chk(input bit avg, input int code, input bit frac, input bit wide,
                           input int base, input int step, input int ch, input string tag);
    int n, sum, d, e;
    logic [15:0] held;
    n = burst_len(avg, code);
    sum = 0;
    for (int i = 0; i < n; i++) begin
      d = (base + i * step) % 4096;
      sum += d;
      put(d, ch);
      if (i == n - 2) chk(res_valid == 1'b0, {tag, " no early result R9"}, res_valid, 0);
    end
    e = expect_word(avg, code, frac, wide, sum);
    chk(res_valid == 1'b1, {tag, " valid after last sample"}, res_valid, 1);
    chk(int'(res_data) == e, {tag, " result"}, res_data, e);
    held = res_data;
    @(negedge clk);
    chk(res_valid == 1'b0 && res_data == held, {tag, " single pulse and hold R9"},
        res_valid, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 0 && res_data == 0 && wr_err == 0, "R1 reset outputs", res_data, 0);
    put(100, 0); put(100, 0);
    chk(res_valid == 0, "R1 filter off after reset", res_valid, 0);
  endtask

  task automatic t_oversample();
    for (int c = 0; c < 4; c++) begin
      wr(cw(1, 0, 0, c, 5), 0, "R2 config os");
      burst_chk(0, c, 0, 0, 37 * c + 11, 97, 5, "R5 os pow4");
    end
    for (int c = 4; c < 8; c++) begin
      wr(cw(1, 0, 0, c, 5), 0, "R2 config os");
      burst_chk(0, c, 0, 0, 2000 + c, 211, 5, "R6 os pow2 frac");
    end
  endtask

  task automatic t_average();
    frac_sel = 1'b0;
    for (int c = 0; c < 8; c++) begin
      wr(cw(1, 1, 1, c, 12), 0, "R2 config avg");
      burst_chk(1, c, 0, 1, 13 + c, 151, 12, "R7 avg");
    end
    frac_sel = 1'b1;
    wr(cw(1, 1, 0, 2, 12), 0, "R2 config avg");
    burst_chk(1, 2, 1, 0, 7, 333, 12, "R8 avg frac wide16 off");
    wr(cw(1, 1, 1, 2, 12), 0, "R2 config avg");
    burst_chk(1, 2, 1, 1, 7, 333, 12, "R8 avg frac wide16 on");
    wr(cw(1, 1, 1, 0, 12), 0, "R2 config avg");
    put(1, 12); put(2, 12);
    chk(res_data == 16'd24, "R8 avg keeps fraction 1.5", res_data, 24);
    frac_sel = 1'b0;
  endtask

  task automatic t_channel();
    wr(cw(1, 0, 0, 4, 3), 0, "R2 config chan");
    put(100, 3); put(500, 7); put(900, 2);
    chk(res_valid == 0, "R4 other channel ignored", res_valid, 0);
    put(200, 3);
    chk(res_valid == 1 && res_data == 300, "R4 matched pair", res_data, 300);
    wr(cw(0, 0, 0, 4, 3), 0, "R2 config off");
    put(50, 3); put(60, 3);
    chk(res_valid == 0, "R4 filter off ignored", res_valid, 0);
    wr(cw(1, 0, 0, 4, 3), 0, "R2 config on");
    smp_valid = 1'b0; smp_data = 12'd999; smp_chan = 4'd3;
    @(negedge clk);
    put(10, 3); put(20, 3);
    chk(res_valid == 1 && res_data == 30, "R4 invalid strobe ignored", res_data, 30);
  endtask

  task automatic t_lock();
    wr(cw(1, 0, 0, 0, 2), 0, "R2 config lock base");
    wr(cw(1, 1, 1, 7, 9), 1, "R3 locked write");
    burst_chk(0, 0, 0, 0, 1000, 3, 2, "R3 old config kept");
  endtask

  task automatic t_abort();
    wr(cw(1, 0, 0, 0, 1), 0, "R2 config abort");
    put(4000, 1); put(4000, 1); put(4000, 1);
    wr(cw(0, 0, 0, 0, 1), 0, "R10 off");
    wr(cw(1, 0, 0, 0, 1), 0, "R10 on");
    put(10, 1); put(10, 1); put(10, 1);
    chk(res_valid == 0, "R10 count restarted", res_valid, 0);
    put(10, 1);
    chk(res_valid == 1 && res_data == 20, "R10 partial discarded", res_data, 20);
    put(3000, 1); put(3000, 1);
    wr(cw(1, 0, 0, 0, 1), 0, "R10 rewrite");
    put(8, 1); put(8, 1); put(8, 1); put(8, 1);
    chk(res_valid == 1 && res_data == 16, "R10 write restarts burst", res_data, 16);
  endtask

  task automatic t_full_scale();
    wr(cw(1, 0, 0, 3, 15), 0, "R2 config full");
    burst_chk(0, 3, 0, 0, 4095, 0, 15, "R11 os full scale");
    chk(res_data == 16'd65520, "R11 os 65520", res_data, 65520);
    wr(cw(1, 1, 0, 7, 15), 0, "R2 config full avg");
    burst_chk(1, 7, 0, 0, 4095, 0, 15, "R11 avg full scale");
    chk(res_data == 16'd65520, "R11 avg 65520", res_data, 65520);
  endtask

  initial begin
    t_reset();
    t_oversample();
    t_average();
    t_channel();
    t_lock();
    t_abort();
    t_full_scale();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule